// File: doc/BRIEF.md
# SAR ADC conversion sequencer

This block is the digital side of a successive-approximation converter. It derives a slower conversion clock from the system clock through a power-of-two prescaler, and counts every phase of a conversion in periods of that clock. A start request opens a sampling window of programmable length, with an optional fixed offset-compensation phase in front of it. It then tries one bit of the trial DAC code per conversion clock, from the most significant bit down to bit 0, and keeps or drops each bit by the comparator's verdict. When the last bit is settled it loads the result word and gives a one-cycle done pulse. The analog comparator, DAC and sample-and-hold sit outside the block.

Two resolutions are available at run time: 12 bits and 8 bits. The 8-bit mode skips the four upper trial bits, so its bit phase is four conversion clocks shorter. In free-running mode the sequencer goes straight from the last bit into a new sampling window without a new request. One conversion takes the sampling length plus the resolution, counted in conversion clocks.

Top module: `sar_seq`

## Requirements
- R1: The conversion clock period is 2^(psel_i+1) system clock cycles for psel_i = 0..7, which gives division factors from 2 to 256. Every phase length below is a whole number of these periods.
- R2: When no offset phase is enabled, an accepted start gives sample_o high for exactly (samp_len_i+1) conversion clock periods. dac_code_o is 0 while sample_o is high.
- R3: After sampling, the bit phase lasts 12 conversion clocks with res8_i=0 and 8 with res8_i=1. It runs from the end of sampling to the rise of done_o.
- R4: Each trial sets the current bit in dac_code_o. The bit is kept when cmp_i=1, meaning the input is at or above the DAC level, and cleared when cmp_i=0. The next lower bit is then tried. With a comparator that reports input >= dac_code_o, result_o equals the input value.
- R5: In 8-bit mode the result and the trial code use bits 7..0, and bits 11..8 are zero.
- R6: done_o is high for exactly one system clock cycle, on the edge at which result_o takes its new value. result_o does not change at any other time.
- R7: When free_run_i=1 at the last bit, sample_o rises on the same edge as done_o. Back-to-back conversions then repeat every (samp_len_i+1+resolution) conversion clocks, with no offset phase between them.
- R8: When offs_en_i=1, a start is followed by 4 conversion clocks in which sample_o is low, and only then by the sampling window.
- R9: A start_i pulse of one cycle given while idle is captured. The conversion begins at the next conversion clock boundary, 1 to P cycles later, where P is the prescaler period. A start_i that arrives while a conversion is in progress is ignored.
- R10: After reset, sample_o, done_o, dac_code_o and result_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion request, one cycle or longer |
| cmp_i | input | 1 | Comparator verdict, 1 when input >= DAC level |
| res8_i | input | 1 | 1 selects 8-bit, 0 selects 12-bit resolution |
| samp_len_i | input | 4 | Sampling length minus one, in conversion clocks |
| offs_en_i | input | 1 | Insert the offset-compensation phase before requested conversions |
| free_run_i | input | 1 | Restart sampling automatically after each conversion |
| psel_i | input | 3 | Prescaler select, period 2^(psel_i+1) cycles |
| dac_code_o | output | 12 | Trial code driven to the DAC |
| sample_o | output | 1 | Sample-and-hold tracking control |
| result_o | output | 12 | Last conversion result, right-aligned |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The bench sweeps all 256 codes at 8 bits and a strided set of codes plus both extremes at 12 bits, against a comparator model. A design that got the keep-or-clear rule wrong, or mis-aligned the narrow result, would give wrong codes near 0, at all-ones, or at bit boundaries. All eight prescaler settings are run, and the sampling and bit phases are measured in system cycles. An off-by-one in a phase counter, or a wrong division factor, shows up as a phase that is one conversion clock too long or too short. Further runs place start pulses in the middle of a conversion, cover the free-running period with and without the offset enable, and turn free running off halfway through. A design that restarted on a stray request, or put the offset phase between free-running conversions, would show extra sampling windows or a longer period.

// File: rtl/sar_seq_pkg.sv
// Package: shared types and constants for the SAR conversion sequencer.
// Assumes: one state encoding shared by the controller and the checker.
package sar_seq_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OFFS = 2'd1,
        ST_SAMP = 2'd2,
        ST_CONV = 2'd3
    } sar_state_e;

    // Fixed length of the offset-compensation phase, in conversion clocks
    localparam int OFFS_TICKS = 4;

endpackage

// File: rtl/sar_prescale.sv
// Module: sar_prescale
// Makes a one-cycle enable, tick_o, once per conversion clock period.
// The period is 2^(psel_i+1) system cycles. A free-running counter is
// compared under a mask, so the period stays aligned when psel_i changes.
// Assumes: the largest period, 2^(2^PSEL_W), fits the counter width.
module sar_prescale #(
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PSEL_W-1:0] psel_i,
    output logic              tick_o
);
    localparam int CNT_W = 1 << PSEL_W;

    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] lim;

    // Mask holds ones in bits 0..psel_i
    genvar gi;
    generate
        for (gi = 0; gi < CNT_W; gi++) begin : g_lim
            assign lim[gi] = (PSEL_W'(gi) <= psel_i);
        end
    endgenerate

    // Free-running divider counter
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Tick when every bit under the mask is set
    assign tick_o = ((div_q & lim) == lim);

endmodule

// File: rtl/sar_ctrl.sv
// Module: sar_ctrl
// Phase controller: idle, offset compensation, sampling and bit trials.
// All phase changes happen on conversion clock ticks. A start request seen
// while idle is held until the next tick. While busy, requests are dropped.
// Assumes: OFFS_TICKS-1 fits in LEN_W bits; last_i comes from the bit register.
module sar_ctrl
    import sar_seq_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             offs_en_i,
    input  logic             free_run_i,
    input  logic [LEN_W-1:0] samp_len_i,
    input  logic             last_i,
    output logic             load_o,
    output logic             step_o,
    output logic             sample_o,
    output logic             done_o
);
    localparam logic [LEN_W-1:0] OFFS_LOAD = LEN_W'(OFFS_TICKS - 1);

    sar_state_e       state_q;
    logic [LEN_W-1:0] cnt_q;
    logic             req_q;
    logic             done_q;
    logic             go;
    logic             cnt_zero;

    assign go       = req_q | start_i;
    assign cnt_zero = (cnt_q == '0);

    // Request latch: only armed while idle, cleared when the tick takes it
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= (state_q == ST_IDLE) && go && !tick_i;
    end

    // Phase register and phase counter, advanced on ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (tick_i) begin
            case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        if (offs_en_i) begin
                            state_q <= ST_OFFS;
                            cnt_q   <= OFFS_LOAD;
                        end else begin
                            state_q <= ST_SAMP;
                            cnt_q   <= samp_len_i;
                        end
                    end
                end
                ST_OFFS: begin
                    if (cnt_zero) begin
                        state_q <= ST_SAMP;
                        cnt_q   <= samp_len_i;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_SAMP: begin
                    if (cnt_zero) state_q <= ST_CONV;
                    else          cnt_q   <= cnt_q - 1'b1;
                end
                ST_CONV: begin
                    if (last_i) begin
                        if (free_run_i) begin
                            state_q <= ST_SAMP;
                            cnt_q   <= samp_len_i;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Done pulse, registered on the edge that stores the final bit
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= step_o && last_i;
    end

    // Strobes to the bit register
    assign load_o   = tick_i && (state_q == ST_SAMP) && cnt_zero;
    assign step_o   = tick_i && (state_q == ST_CONV);
    assign sample_o = (state_q == ST_SAMP);
    assign done_o   = done_q;

endmodule

// File: rtl/sar_bitreg.sv
// Module: sar_bitreg
// Successive-approximation register. On load, a one-hot trial mask is set
// to the top bit of the chosen width, and the trial code takes that mask.
// On each step the current bit is kept or cleared by the comparator and the
// next lower bit is tried. After bit 0 the result word is stored and the
// trial code goes back to zero.
// Assumes: NARROW_W <= DATA_W; load and step are never high together.
module sar_bitreg #(
    parameter int DATA_W   = 12,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              narrow_i,
    input  logic              cmp_i,
    output logic [DATA_W-1:0] code_o,
    output logic [DATA_W-1:0] result_o,
    output logic              last_o,
    output logic              narrow_o
);
    localparam logic [DATA_W-1:0] TOP_WIDE   = DATA_W'(1) << (DATA_W - 1);
    localparam logic [DATA_W-1:0] TOP_NARROW = DATA_W'(1) << (NARROW_W - 1);

    logic [DATA_W-1:0] code_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] res_q;
    logic [DATA_W-1:0] decided;
    logic              narrow_q;

    // Per-bit decision: the bit under trial takes the comparator verdict
    genvar gb;
    generate
        for (gb = 0; gb < DATA_W; gb++) begin : g_bit
            assign decided[gb] = mask_q[gb] ? cmp_i : code_q[gb];
        end
    endgenerate

    // Trial code and mask walk from the top bit down to bit 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (load_i) begin
            code_q <= narrow_i ? TOP_NARROW : TOP_WIDE;
            mask_q <= narrow_i ? TOP_NARROW : TOP_WIDE;
        end else if (step_i) begin
            if (mask_q[0]) begin
                code_q <= '0;
                mask_q <= '0;
            end else begin
                code_q <= decided | (mask_q >> 1);
                mask_q <= mask_q >> 1;
            end
        end
    end

    // Result word, written once per conversion after bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)                    res_q <= '0;
        else if (step_i && mask_q[0])  res_q <= decided;
    end

    // Resolution of the conversion in progress
    always_ff @(posedge clk) begin
        if (!rst_n)      narrow_q <= 1'b0;
        else if (load_i) narrow_q <= narrow_i;
    end

    assign code_o   = code_q;
    assign result_o = res_q;
    assign last_o   = mask_q[0];
    assign narrow_o = narrow_q;

endmodule

// File: rtl/sar_seq.sv
// Module: sar_seq (top)
// SAR conversion sequencer: a prescaler, a phase controller and a bit register.
// Assumes: the comparator output is settled within one conversion clock of
// a code change; settings are held steady during a conversion.
module sar_seq #(
    parameter int DATA_W   = 12,
    parameter int NARROW_W = 8,
    parameter int LEN_W    = 4,
    parameter int PSEL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_i,
    input  logic              res8_i,
    input  logic [LEN_W-1:0]  samp_len_i,
    input  logic              offs_en_i,
    input  logic              free_run_i,
    input  logic [PSEL_W-1:0] psel_i,
    output logic [DATA_W-1:0] dac_code_o,
    output logic              sample_o,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o
);
    logic tick;
    logic load;
    logic step;
    logic last;
    logic narrow_q;

    // Conversion clock enable
    sar_prescale #(.PSEL_W(PSEL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .psel_i (psel_i),
        .tick_o (tick)
    );

    // Phase sequencing
    sar_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .start_i    (start_i),
        .offs_en_i  (offs_en_i),
        .free_run_i (free_run_i),
        .samp_len_i (samp_len_i),
        .last_i     (last),
        .load_o     (load),
        .step_o     (step),
        .sample_o   (sample_o),
        .done_o     (done_o)
    );

    // Successive-approximation register
    sar_bitreg #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .narrow_i (res8_i),
        .cmp_i    (cmp_i),
        .code_o   (dac_code_o),
        .result_o (result_o),
        .last_o   (last),
        .narrow_o (narrow_q)
    );

endmodule

// File: rtl/sar_seq_chk.sv
// Module: sar_seq_chk
// Assertion checker, bound to sar_seq. Watches the ports and the
// prescaler tick and latched resolution inside the top.
// Assumes: DATA_W > NARROW_W.
module sar_seq_chk #(
    parameter int DATA_W   = 12,
    parameter int NARROW_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              narrow_q,
    input logic              free_run_i,
    input logic              sample_o,
    input logic              done_o,
    input logic [DATA_W-1:0] dac_code_o,
    input logic [DATA_W-1:0] result_o
);
    // R1: the smallest division is 2, so ticks never come back to back
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R2: the DAC is parked at zero while sampling
    p_samp_dac_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (dac_code_o == '0));

    // R5: narrow conversions never drive the upper code bits
    p_narrow_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_q |-> (dac_code_o[DATA_W-1:NARROW_W] == '0));

    // R5: narrow results come out right-aligned
    p_narrow_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && narrow_q) |-> (result_o[DATA_W-1:NARROW_W] == '0));

    // R6: done is a single-cycle pulse
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: the result only moves together with done
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R7: free running re-enters sampling on the done edge
    p_free_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(free_run_i)) |-> sample_o);

endmodule

bind sar_seq sar_seq_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .narrow_q   (narrow_q),
    .free_run_i (free_run_i),
    .sample_o   (sample_o),
    .done_o     (done_o),
    .dac_code_o (dac_code_o),
    .result_o   (result_o)
);

// File: tb/sar_seq_bench.sv
// Bench for sar_seq. A comparator model drives cmp_i from an input level.
// Phase lengths are measured in system cycles at falling edges.
module sar_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cmp_i;
    logic        res8_i = 1'b0;
    logic [3:0]  samp_len_i = 4'd0;
    logic        offs_en_i = 1'b0;
    logic        free_run_i = 1'b0;
    logic [2:0]  psel_i = 3'd0;
    logic [11:0] dac_code_o;
    logic        sample_o;
    logic [11:0] result_o;
    logic        done_o;
    logic [11:0] vin = 12'd0;

    integer errors = 0;
    integer checks = 0;

    always #2 clk = ~clk;

    // Comparator model: input at or above the DAC level
    assign cmp_i = (vin >= dac_code_o);

    sar_seq u_sar_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .res8_i(res8_i), .samp_len_i(samp_len_i), .offs_en_i(offs_en_i),
        .free_run_i(free_run_i), .psel_i(psel_i), .dac_code_o(dac_code_o),
        .sample_o(sample_o), .result_o(result_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input integer act, input integer exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One requested conversion with full timing measurement
    task automatic run_one(input logic [11:0] v, input logic n8, input logic [3:0] len,
                           input logic [2:0] ps, input logic off, input bit poke);
        integer p, d, sl, cl, nb;
        p  = 2 << ps;
        nb = n8 ? 8 : 12;
        vin = v; res8_i = n8; samp_len_i = len; psel_i = ps; offs_en_i = off;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        d = 1;
        while (!sample_o && d < 6000) begin @(negedge clk); d++; end
        if (off) chk(d >= 4*p+1 && d <= 5*p, "R8 offset delay", d, 4*p+1);
        else     chk(d >= 1 && d <= p, "R9 start latency", d, p);
        sl = 0;
        while (sample_o && sl < 6000) begin
            sl++;
            if (poke) start_i = (sl == 2);
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(sl == (len+1)*p, "R2 sampling length", sl, (len+1)*p);
        cl = 0;
        while (!done_o && cl < 6000) begin
            cl++;
            if (poke) start_i = (cl == 3);
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(cl == nb*p, "R3 bit phase length", cl, nb*p);
        chk(result_o == (n8 ? {4'd0, v[7:0]} : v), "R4 result value", result_o, v);
        if (n8) chk(result_o[11:8] == 4'd0, "R5 narrow alignment", result_o[11:8], 0);
        @(negedge clk);
        chk(!done_o, "R6 done width", done_o, 0);
    endtask

    task automatic idle_watch(input integer n, input string tag);
        integer hits;
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sample_o || done_o) hits++;
        end
        chk(hits == 0, tag, hits, 0);
    endtask

    // Watchdog
    initial begin
        #(4 * 190000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        integer t0, per;
        logic [11:0] r0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!sample_o && !done_o && dac_code_o == 0 && result_o == 0,
            "R10 reset state", {sample_o, done_o, dac_code_o, result_o}, 0);

        // R4 R5: every 8-bit code, shortest setup
        for (int v = 0; v < 256; v++) run_one(12'(v), 1'b1, 4'd0, 3'd0, 1'b0, 1'b0);

        // R4: 12-bit extremes and a strided sweep
        run_one(12'd0, 1'b0, 4'd3, 3'd0, 1'b0, 1'b0);
        run_one(12'hFFF, 1'b0, 4'd3, 3'd0, 1'b0, 1'b0);
        for (int v = 0; v < 4096; v += 67) run_one(12'(v), 1'b0, 4'd1, 3'd0, 1'b0, 1'b0);

        // R1: every prescaler setting
        for (int ps = 0; ps < 8; ps++) run_one(12'h5A, 1'b1, 4'd1, 3'(ps), 1'b0, 1'b0);

        // R2: longest sampling window
        run_one(12'h800, 1'b0, 4'd15, 3'd1, 1'b0, 1'b0);

        // R8: offset phase at two prescaler settings
        run_one(12'h123, 1'b0, 4'd3, 3'd0, 1'b1, 1'b0);
        run_one(12'h7F, 1'b1, 4'd2, 3'd2, 1'b1, 1'b0);

        // R9: starts during sampling and bit phase are ignored
        run_one(12'h9C3, 1'b0, 4'd3, 3'd1, 1'b0, 1'b1);
        idle_watch(80, "R9 no restart after ignored start");

        // R7: free running, offset enabled but skipped between conversions
        vin = 12'hA5C; res8_i = 1'b0; samp_len_i = 4'd3; psel_i = 3'd0;
        offs_en_i = 1'b1; free_run_i = 1'b1;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        t0 = 0;
        while (!done_o && t0 < 6000) begin @(negedge clk); t0++; end
        chk(sample_o, "R7 sampling on done edge", sample_o, 1);
        chk(result_o == 12'hA5C, "R7 first result", result_o, 12'hA5C);
        vin = 12'h3E1;
        @(negedge clk);
        per = 1;
        while (!done_o && per < 6000) begin @(negedge clk); per++; end
        chk(per == 32, "R7 free-run period", per, 32);
        chk(result_o == 12'h3E1, "R7 second result", result_o, 12'h3E1);
        r0 = result_o;
        free_run_i = 1'b0;
        @(negedge clk);
        per = 1;
        while (!done_o && per < 6000) begin @(negedge clk); per++; end
        chk(per == 32 && result_o == r0, "R7 last free-run conversion", per, 32);
        idle_watch(60, "R7 idle after free-run off");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule